// File: doc/BRIEF.md
# Serial Port Register and Interrupt Front End

This block is the software-facing side of a serial port. A simple word-addressed bus reads and writes a small set of registers: the data port, the receive error status, the status flags, the two baud divisors, line control, control, FIFO level select, the interrupt mask, the raw and masked interrupt status, the interrupt clear register and a block of identification bytes. Reads can have side effects. A data read pops the receive FIFO and updates the receive interrupt state. Writes to the status and clear registers remove bits.

Received bytes arrive on a valid/ready stream and fill an internal receive FIFO. The FIFO holds `DEPTH` bytes when line control bit 4 is set and a single byte when it is clear. A byte written to the data register completes at once: it leaves on a one-cycle `tx_valid` strobe, or, in loopback, it goes into the receive FIFO. The transmit side never holds data, so it always reports empty. Baud counting, serializer timing and modem lines belong to other blocks.

Back-pressure rules: a byte on the receive stream moves on a clock edge where `rx_valid` and `rx_ready` are both high. `rx_ready` is low in any cycle that carries a bus access. With loopback off, it is also low while the FIFO is at capacity. With loopback on, `rx_ready` stays high outside bus accesses and the accepted bytes are thrown away. `tx_valid` has no ready signal: each strobe carries a byte that is already done.

Top module: `uart_regfront`

## Requirements
- R1: After reset, every register reads 0, except three. Flags read 0x0090. Level select reads 0x0012. The identification bytes read their fixed values. `irq` is low.
- R2: Writes keep only the implemented bits:
  - integer divisor (0x09): all 16 bits
  - fractional divisor (0x0A): bits 5:0
  - line control (0x0B): bits 7:0
  - control (0x0C): the bits set in 0xFFC7
  - level select (0x0D): bits 5:0
  - interrupt mask (0x0E): bits 10:0
- R3: Any write to the data register (0x00) sets raw interrupt bit 5 (transmit). With control bit 7 (loopback) clear, the cycle after the write shows `tx_valid`=1 and `tx_data` = write data bits 7:0. The FIFO is not changed.
- R4: With loopback set, a data write pushes write data bits 7:0 into the receive FIFO. If the FIFO is at capacity, the byte is dropped and the overrun bit is set. A data read (0x00) pops the oldest byte and returns it in bits 7:0, with the receive status byte in bits 15:8. If the FIFO is empty, the byte field is 0.
- R5: Receive status (0x01) reads the overrun flag at bit 3. Any write to 0x01 clears the flag.
- R6: The flags register (0x06) reads as follows:
  - bit 7 (transmit empty) is always 1
  - bit 6 (receive full) is 1 when the count equals the capacity
  - bit 5 (transmit full) is always 0
  - bit 4 (receive empty) is 1 when the count is 0

  Capacity is `DEPTH` when line control bit 4 is set and 1 when it is clear. A line control write that changes bit 4 empties the FIFO.
- R7: Receive interrupt (raw bit 4):
  - A push sets it when the count moves from below the trigger level to at or above it.
  - A data read clears it when the count left after the read is below the level.
  - With line control bit 4 clear, the level is 1.
  - With bit 4 set, level select bits 5:3 choose the level: 0→DEPTH/8, 1→DEPTH/4, 2→DEPTH/2, 3→3·DEPTH/4, 4→7·DEPTH/8, 5 to 7→DEPTH.
- R8: Receive timeout interrupt (raw bit 6): every successful push sets it. A data read that leaves the FIFO empty clears it.
- R9: A write to the clear register (0x11) clears each raw status bit whose write-data bit is 1. Reading 0x11 returns 0.
- R10: Raw status (0x0F) and masked status (0x10) behave as follows:
  - Masked status reads raw AND mask.
  - `irq` shows whether that value is non-zero.
  - `irq` changes on the same clock edge as the state the access changes.
- R11: Addresses 0x3F8 to 0x3FF read 0x11, 0x10, 0x24, 0x00, 0x0D, 0xF0, 0x05 and 0xB1, in that order.
- R12: Reads of unassigned addresses return 0. Writes to read-only or unassigned addresses change nothing.
- R13: `rx_ready` follows the back-pressure rules above. Bytes accepted with loopback off are read back in arrival order. Bytes accepted with loopback on never reach the FIFO.
- R14: The cycle after every read access shows `rsp_valid`=1 with the read data on `rsp_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address |
| bus_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid (cycle after a read) |
| rsp_data | output | 16 | Read data |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Received byte accepted |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Transmitted byte strobe |
| tx_data | output | 8 | Transmitted byte |
| irq | output | 1 | Level interrupt |

## Verification
The bench walks every trigger-level selection with the FIFO on and off. For each one it fills the FIFO one byte at a time to capacity and past it, then drains it. After every step it compares the raw status and the flags with the arithmetic level. A design that set the receive bit at the wrong count, or kept the timeout bit after the last pop, would fail at that exact step. A design that lost the overrun byte into the FIFO would return an extra byte, and one that failed to clear overrun on a status write would keep reporting 0x08 in the upper data bits. The bench also covers several other failure modes:
- A sweep over all 2048 mask values catches a wrong masked-status or interrupt bit.
- Full read and write sweeps of the address space catch a stray decode or an ignored write that lands.
- A streaming test catches a `rx_ready` that drops at the wrong count, stays high during a bus access, or lets loopback-time input into the FIFO.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;
  localparam int unsigned ADDR_W = 10;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned IRQ_W  = 11;

  localparam logic [ADDR_W-1:0] A_DATA  = 10'h000;
  localparam logic [ADDR_W-1:0] A_RSTAT = 10'h001;
  localparam logic [ADDR_W-1:0] A_FLAGS = 10'h006;
  localparam logic [ADDR_W-1:0] A_DIVI  = 10'h009;
  localparam logic [ADDR_W-1:0] A_DIVF  = 10'h00A;
  localparam logic [ADDR_W-1:0] A_LINE  = 10'h00B;
  localparam logic [ADDR_W-1:0] A_CTRL  = 10'h00C;
  localparam logic [ADDR_W-1:0] A_LVL   = 10'h00D;
  localparam logic [ADDR_W-1:0] A_MASK  = 10'h00E;
  localparam logic [ADDR_W-1:0] A_RAW   = 10'h00F;
  localparam logic [ADDR_W-1:0] A_MSK   = 10'h010;
  localparam logic [ADDR_W-1:0] A_CLR   = 10'h011;
  localparam logic [ADDR_W-1:0] A_ID_LO = 10'h3F8;

  // interrupt bit positions (software decodes them)
  localparam int unsigned IB_RX  = 4;
  localparam int unsigned IB_TX  = 5;
  localparam int unsigned IB_RTO = 6;
  localparam int unsigned OVR_BIT  = 3;
  localparam int unsigned LOOP_BIT = 7;
  localparam int unsigned FEN_BIT  = 4;

  localparam logic [15:0] M_DIVF = 16'h003F;
  localparam logic [15:0] M_LINE = 16'h00FF;
  localparam logic [15:0] M_CTRL = 16'hFFC7;
  localparam logic [15:0] M_LVL  = 16'h003F;
  localparam logic [5:0]  LVL_RESET = 6'h12;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: return 8'h11;
      3'd1: return 8'h10;
      3'd2: return 8'h24;
      3'd3: return 8'h00;
      3'd4: return 8'h0D;
      3'd5: return 8'hF0;
      3'd6: return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/uart_fe_rxfifo.sv
module uart_fe_rxfifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned PW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wide,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] rptr_q, wptr_q;
  logic [CW-1:0] count_q;
  logic do_push, do_pop;

  assign full    = wide ? (count_q == CW'(DEPTH)) : (count_q != '0);
  assign do_push = push && !full;
  assign do_pop  = pop && (count_q != '0);
  assign head    = mem[rptr_q];
  assign count   = count_q;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rptr_q  <= '0;
      wptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (do_push) wptr_q <= wptr_q + 1'b1;
      if (do_pop)  rptr_q <= rptr_q + 1'b1;
      count_q <= count_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wptr_q] <= push_data;
  end
endmodule

// File: rtl/uart_fe_trig.sv
module uart_fe_trig #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          fifo_en,
  input  logic [2:0]    sel,
  output logic [CW-1:0] level
);
  localparam logic [CW-1:0] L_EIGHTH = CW'(DEPTH / 8);
  localparam logic [CW-1:0] L_QUART  = CW'(DEPTH / 4);
  localparam logic [CW-1:0] L_HALF   = CW'(DEPTH / 2);
  localparam logic [CW-1:0] L_3Q     = CW'(DEPTH * 3 / 4);
  localparam logic [CW-1:0] L_7E     = CW'(DEPTH * 7 / 8);
  localparam logic [CW-1:0] L_FULL   = CW'(DEPTH);

  always_comb begin
    if (!fifo_en) level = CW'(1);
    else begin
      case (sel)
        3'd0: level = L_EIGHTH;
        3'd1: level = L_QUART;
        3'd2: level = L_HALF;
        3'd3: level = L_3Q;
        3'd4: level = L_7E;
        default: level = L_FULL;
      endcase
    end
  end
endmodule

// File: rtl/uart_fe_irq.sv
module uart_fe_irq #(
  parameter int unsigned W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_bits,
  input  logic [W-1:0] clr_bits,
  input  logic [W-1:0] mask_next,
  output logic [W-1:0] raw,
  output logic         irq
);
  logic [W-1:0] raw_q, raw_d;
  logic irq_q;

  assign raw_d = (raw_q & ~clr_bits) | set_bits;
  assign raw   = raw_q;
  assign irq   = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q <= '0;
      irq_q <= 1'b0;
    end else begin
      raw_q <= raw_d;
      irq_q <= |(raw_d & mask_next);
    end
  end
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_fe_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              irq
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  // configuration state
  logic [15:0] divi_q, ctrl_q;
  logic [5:0]  divf_q, lvl_q;
  logic [7:0]  line_q;
  logic [IRQ_W-1:0] imsc_q;
  logic oe_q;
  logic tx_valid_q, rsp_valid_q;
  logic [7:0] tx_data_q;
  logic [DATA_W-1:0] rsp_data_q, rd_mux;

  logic wr, rd, loop_en, fifo_en;
  logic hit_data, hit_rstat, hit_line, hit_mask, hit_clr;
  logic lb_write, lb_push, overrun, ext_push, push_any, pop, flush;
  logic [7:0] push_byte, head;
  logic [CW-1:0] fifo_count, level, left_after_pop;
  logic fifo_full;
  logic [IRQ_W-1:0] set_bits, clr_bits, mask_next, raw_bits;
  logic [7:0] rstat_byte;

  assign wr      = bus_valid && bus_write;
  assign rd      = bus_valid && !bus_write;
  assign loop_en = ctrl_q[LOOP_BIT];
  assign fifo_en = line_q[FEN_BIT];

  assign hit_data  = bus_addr == A_DATA;
  assign hit_rstat = bus_addr == A_RSTAT;
  assign hit_line  = bus_addr == A_LINE;
  assign hit_mask  = bus_addr == A_MASK;
  assign hit_clr   = bus_addr == A_CLR;

  // receive ingress and loopback
  assign rx_ready  = !bus_valid && (loop_en || !fifo_full);
  assign ext_push  = rx_valid && rx_ready && !loop_en;
  assign lb_write  = wr && hit_data && loop_en;
  assign lb_push   = lb_write && !fifo_full;
  assign overrun   = lb_write && fifo_full;
  assign push_any  = lb_push || ext_push;
  assign push_byte = lb_push ? bus_wdata[7:0] : rx_data;
  assign pop       = rd && hit_data;
  assign flush     = wr && hit_line && (bus_wdata[FEN_BIT] != line_q[FEN_BIT]);

  uart_fe_rxfifo #(.DEPTH(DEPTH), .WIDTH(8)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wide(fifo_en),
    .push(push_any), .push_data(push_byte), .pop(pop),
    .head(head), .count(fifo_count), .full(fifo_full)
  );

  uart_fe_trig #(.DEPTH(DEPTH)) u_trig (
    .fifo_en(fifo_en), .sel(lvl_q[5:3]), .level(level)
  );

  // interrupt events
  assign left_after_pop = (fifo_count == '0) ? '0 : fifo_count - 1'b1;

  always_comb begin
    set_bits = '0;
    clr_bits = '0;
    if (push_any) begin
      set_bits[IB_RTO] = 1'b1;
      if (fifo_count < level && ({1'b0, fifo_count} + 1'b1) >= {1'b0, level})
        set_bits[IB_RX] = 1'b1;
    end
    if (wr && hit_data) set_bits[IB_TX] = 1'b1;
    if (wr && hit_clr)  clr_bits = bus_wdata[IRQ_W-1:0];
    if (pop) begin
      if (left_after_pop < level) clr_bits[IB_RX]  = 1'b1;
      if (left_after_pop == '0)   clr_bits[IB_RTO] = 1'b1;
    end
  end

  assign mask_next = (wr && hit_mask) ? bus_wdata[IRQ_W-1:0] : imsc_q;

  uart_fe_irq #(.W(IRQ_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_bits(set_bits), .clr_bits(clr_bits),
    .mask_next(mask_next), .raw(raw_bits), .irq(irq)
  );

  // read path
  assign rstat_byte = 8'(oe_q) << OVR_BIT;

  always_comb begin
    rd_mux = '0;
    if (bus_addr >= A_ID_LO) rd_mux = {8'h00, id_byte(bus_addr[2:0])};
    else begin
      case (bus_addr)
        A_DATA:  rd_mux = {rstat_byte, (fifo_count != '0) ? head : 8'h00};
        A_RSTAT: rd_mux = {8'h00, rstat_byte};
        A_FLAGS: rd_mux = {8'h00, 1'b1, fifo_full, 1'b0, fifo_count == '0, 4'h0};
        A_DIVI:  rd_mux = divi_q;
        A_DIVF:  rd_mux = {10'h000, divf_q};
        A_LINE:  rd_mux = {8'h00, line_q};
        A_CTRL:  rd_mux = ctrl_q;
        A_LVL:   rd_mux = {10'h000, lvl_q};
        A_MASK:  rd_mux = {5'h00, imsc_q};
        A_RAW:   rd_mux = {5'h00, raw_bits};
        A_MSK:   rd_mux = {5'h00, raw_bits & imsc_q};
        default: rd_mux = '0;
      endcase
    end
  end

  // register updates
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      divi_q <= '0; divf_q <= '0; line_q <= '0; ctrl_q <= '0;
      lvl_q <= LVL_RESET; imsc_q <= '0; oe_q <= 1'b0;
      tx_valid_q <= 1'b0; tx_data_q <= '0;
      rsp_valid_q <= 1'b0; rsp_data_q <= '0;
    end else begin
      tx_valid_q  <= wr && hit_data && !loop_en;
      rsp_valid_q <= rd;
      if (wr && hit_data && !loop_en) tx_data_q <= bus_wdata[7:0];
      if (rd) rsp_data_q <= rd_mux;
      if (overrun) oe_q <= 1'b1;
      if (wr) begin
        case (bus_addr)
          A_RSTAT: oe_q   <= 1'b0;
          A_DIVI:  divi_q <= bus_wdata;
          A_DIVF:  divf_q <= bus_wdata[5:0] & M_DIVF[5:0];
          A_LINE:  line_q <= bus_wdata[7:0] & M_LINE[7:0];
          A_CTRL:  ctrl_q <= bus_wdata & M_CTRL;
          A_LVL:   lvl_q  <= bus_wdata[5:0] & M_LVL[5:0];
          A_MASK:  imsc_q <= bus_wdata[IRQ_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assign tx_valid  = tx_valid_q;
  assign tx_data   = tx_data_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
endmodule

// File: rtl/uart_regfront_chk.sv
module uart_regfront_chk
  import uart_fe_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              rsp_valid,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic              irq,
  input logic              loop_en,
  input logic              fifo_en,
  input logic [CW-1:0]     fifo_count,
  input logic              oe_q,
  input logic [IRQ_W-1:0]  raw_bits,
  input logic [IRQ_W-1:0]  imsc_q
);
  // R10: the line follows raw AND mask of the held state
  a_r10_irq_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(raw_bits & imsc_q));

  // R13: no ingress during a bus access
  a_r13_ready_low_on_access: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> !rx_ready);

  // R5: status write clears overrun
  a_r5_status_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == A_RSTAT) |=> !oe_q);

  // R3: a transmit strobe only follows a non-loopback data write
  a_r3_tx_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(bus_valid && bus_write && bus_addr == A_DATA && !loop_en));

  // R6: occupancy never passes the capacity
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= (fifo_en ? CW'(DEPTH) : CW'(1)));

  // R9: written ones are gone afterwards
  a_r9_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == A_CLR) |=>
      ((raw_bits & $past(bus_wdata[IRQ_W-1:0])) == '0));

  // R14: every read gets a response
  a_r14_read_response: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> rsp_valid);
endmodule

bind uart_regfront uart_regfront_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rsp_valid(rsp_valid),
  .rx_ready(rx_ready), .tx_valid(tx_valid), .irq(irq), .loop_en(loop_en),
  .fifo_en(fifo_en), .fifo_count(fifo_count), .oe_q(oe_q),
  .raw_bits(raw_bits), .imsc_q(imsc_q)
);

// File: tb/uart_regfront_bench.sv
module uart_regfront_bench;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [9:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic rsp_valid, rx_ready, tx_valid, irq;
  logic [15:0] rsp_data;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = '0, tx_data;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  uart_regfront #(.DEPTH(DEPTH)) u_uart_regfront (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = rsp_data;
    chk("R14 rsp_valid", rsp_valid, 1);
  endtask

  task automatic rdchk(input string tag, input logic [9:0] a, input logic [15:0] e);
    logic [15:0] d;
    rd(a, d);
    chk(tag, d, e);
  endtask

  function automatic logic [15:0] reset_val(input logic [9:0] a);
    case (a)
      10'h006: return 16'h0090;
      10'h00D: return 16'h0012;
      10'h3F8: return 16'h11; 10'h3F9: return 16'h10;
      10'h3FA: return 16'h24; 10'h3FB: return 16'h00;
      10'h3FC: return 16'h0D; 10'h3FD: return 16'hF0;
      10'h3FE: return 16'h05; 10'h3FF: return 16'hB1;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic bit writable(input logic [9:0] a);
    return a == 10'h000 || a == 10'h001 || (a >= 10'h009 && a <= 10'h00E) || a == 10'h011;
  endfunction

  function automatic int trig(input bit fen, input int sel);
    if (!fen) return 1;
    case (sel)
      0: return DEPTH / 8;
      1: return DEPTH / 4;
      2: return DEPTH / 2;
      3: return DEPTH * 3 / 4;
      4: return DEPTH * 7 / 8;
      default: return DEPTH;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int acc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R11: full address sweep in reset state
    chk("R1 irq after reset", irq, 0);
    for (int a = 0; a < 1024; a++) rdchk("R1 R11 reset read", 10'(a), reset_val(10'(a)));

    // R12: writes to read-only and unassigned addresses are ignored
    for (int a = 0; a < 1024; a++) if (!writable(10'(a))) wr(10'(a), 16'hFFFF);
    for (int a = 0; a < 1024; a++) rdchk("R12 read after stray writes", 10'(a), reset_val(10'(a)));
    chk("R12 irq quiet", irq, 0);

    // R2: write masking
    begin
      logic [9:0]  addrs [6] = '{10'h009, 10'h00A, 10'h00B, 10'h00C, 10'h00D, 10'h00E};
      logic [15:0] masks [6] = '{16'hFFFF, 16'h003F, 16'h00FF, 16'hFFC7, 16'h003F, 16'h07FF};
      logic [15:0] pats  [6] = '{16'hFFFF, 16'hA5A5, 16'h5A5A, 16'h1234, 16'hEDCB, 16'h0000};
      for (int r = 0; r < 6; r++)
        for (int p = 0; p < 6; p++) begin
          wr(addrs[r], pats[p]);
          rdchk("R2 masked write", addrs[r], pats[p] & masks[r]);
        end
    end

    // R3: data write with loopback clear
    for (int b = 0; b < 4; b++) begin
      wr(10'h011, 16'h07FF);
      wr(10'h000, 16'hFF00 | 16'(b * 37 + 5));
      chk("R3 tx_valid", tx_valid, 1);
      chk("R3 tx_data", tx_data, 8'(b * 37 + 5));
      @(negedge clk);
      chk("R3 tx strobe one cycle", tx_valid, 0);
      rdchk("R3 raw tx bit", 10'h00F, 16'h0020);
      rdchk("R3 fifo untouched", 10'h006, 16'h0090);
    end

    // R4 R5 R6 R7 R8: loopback fill and drain for every level and mode
    for (int fen = 0; fen < 2; fen++)
      for (int sel = 0; sel < 8; sel++) begin
        int cap, lvl;
        cap = fen ? DEPTH : 1;
        lvl = trig(fen[0], sel);
        wr(10'h00B, fen ? 16'h0010 : 16'h0000);
        wr(10'h00D, 16'(sel << 3));
        wr(10'h00C, 16'h0080);
        wr(10'h011, 16'h07FF);
        for (int k = 1; k <= cap; k++) begin
          wr(10'h000, 16'((k * 13 + sel) & 8'hFF));
          rdchk("R7 R8 raw after push", 10'h00F,
                16'h0060 | ((k >= lvl) ? 16'h0010 : 16'h0000));
          rdchk("R6 flags after push", 10'h006,
                16'h0080 | ((k == cap) ? 16'h0040 : 16'h0000));
        end
        wr(10'h000, 16'h00EE);
        rdchk("R4 R5 overrun flag", 10'h001, 16'h0008);
        for (int j = 1; j <= cap; j++) begin
          int left;
          left = cap - j;
          rdchk("R4 popped byte", 10'h000,
                ((j == 1) ? 16'h0800 : 16'h0000) | 16'((j * 13 + sel) & 8'hFF));
          if (j == 1) begin
            wr(10'h001, 16'h0000);
            rdchk("R5 status cleared", 10'h001, 16'h0000);
          end
          rdchk("R7 R8 raw after pop", 10'h00F,
                16'h0020 | ((left >= lvl) ? 16'h0010 : 16'h0000) |
                ((left > 0) ? 16'h0040 : 16'h0000));
          rdchk("R6 flags after pop", 10'h006,
                16'h0080 | ((left == 0) ? 16'h0010 : 16'h0000));
        end
        rdchk("R4 empty read, dropped byte absent", 10'h000, 16'h0000);
      end

    // R13: stream ingress
    wr(10'h00C, 16'h0000);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'hAA;
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 10'h006;
    #1 chk("R13 ready low during access", rx_ready, 0);
    @(negedge clk);
    bus_valid = 1'b0; rx_valid = 1'b0;
    rdchk("R13 nothing taken during access", 10'h006, 16'h0090);
    acc = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = 8'(i + 64);
      #1 if (rx_ready) acc++;
    end
    @(negedge clk);
    rx_valid = 1'b0;
    chk("R13 accepted up to capacity", acc, DEPTH);
    chk("R13 ready low when full", rx_ready, 0);
    rdchk("R6 flags full", 10'h006, 16'h00C0);
    for (int i = 0; i < DEPTH; i++) rdchk("R13 arrival order", 10'h000, 16'(i + 64));
    wr(10'h00C, 16'h0080);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = 8'h5C;
      #1 chk("R13 loopback ready high", rx_ready, 1);
    end
    @(negedge clk);
    rx_valid = 1'b0;
    rdchk("R13 loopback discards input", 10'h006, 16'h0090);

    // R9: clear register
    wr(10'h00B, 16'h0000);
    wr(10'h011, 16'h07FF);
    wr(10'h000, 16'h0042);
    rdchk("R9 raw set", 10'h00F, 16'h0070);
    wr(10'h011, 16'h0010);
    rdchk("R9 clear rx only", 10'h00F, 16'h0060);
    wr(10'h011, 16'h000F);
    rdchk("R9 zeros keep bits", 10'h00F, 16'h0060);
    wr(10'h011, 16'hFFFF);
    rdchk("R9 clear all", 10'h00F, 16'h0000);
    rdchk("R9 clear reads zero", 10'h011, 16'h0000);
    rdchk("R4 pop leftover", 10'h000, 16'h0042);
    wr(10'h000, 16'h0033);
    rdchk("R8 R7 raw reset up", 10'h00F, 16'h0070);

    // R10: exhaustive mask sweep
    for (int m = 0; m < 2048; m++) begin
      wr(10'h00E, 16'(m));
      chk("R10 irq level", irq, ((m & 16'h70) != 0) ? 1 : 0);
      rdchk("R10 masked status", 10'h010, 16'(m) & 16'h0070);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule